// File: doc/BRIEF.md
# Pointer-Steered Dual Counter Sampler

Two counters run together while a `go` input is held high. The first is a narrow down counter that acts as a pointer. The second is a wide up counter that supplies data. Each counting cycle, the pointer decides which of two small capture registers loads a window of the data counter. While the pointer is in the lower half of its range, register A loads the window that starts at bit 2. While the pointer is in the upper half, register B loads the window that starts at bit 6. The capture registers are the only outputs.

A synchronous reset puts both counters back at their start values and clears both registers. Reset may arrive at any point in a run, and it wins over `go`. Because the pointer starts at its all-ones value, a run begins with a block of B captures followed by a block of A captures. The pattern then repeats every time the pointer wraps.

Top module: `psds_top`

## Requirements
- R1: In the cycle after a clock edge where `rst` is 1, `sampleA` and `sampleB` are 0. On that edge the pointer is set to all ones (0xF at the default width) and the data counter is set to 0.
- R2: Each edge with `go`=1 and `rst`=0 lowers the pointer by one. The pointer wraps from 0 to all ones, so a run captures into B for 8 cycles, then into A for 8 cycles, and repeats.
- R3: Each edge with `go`=1 and `rst`=0 raises the data counter by one. The counter wraps from its maximum value to 0.
- R4: On an edge with `go`=1, `rst`=0 and a pointer value below 8, `sampleA` loads data bits [5:2] and `sampleB` keeps its value.
- R5: On an edge with `go`=1, `rst`=0 and a pointer value of 8 or more, `sampleB` loads data bits [9:6] and `sampleA` keeps its value.
- R6: On an edge with `go`=0 and `rst`=0, both counters and both outputs keep their values.
- R7: A reset during a run, with `go` still 1, re-initialises everything as in R1. The next counting cycle starts again from pointer all ones and data 0.
- R8: The capture decision and the captured slice both use the pointer and data values present before the edge, not the values after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| go | input | 1 | Count and capture enable |
| sampleA | output | REG_W | Capture register A |
| sampleB | output | REG_W | Capture register B |

## Verification
The bench builds the block with the data counter narrowed to 10 bits. That is the smallest width that still holds both capture windows. At this width the data counter wraps after 1024 counting cycles, so the R3 wrap is reached in a short run. Every bit that either register samples still changes during that run. The pointer keeps its default 4-bit width, so each run crosses the pointer wrap and the A/B split many times. A reset is also applied with `go` held high in the middle of a run.

// File: rtl/psds_pkg.sv
package psds_pkg;
  localparam int NUM_LANES = 2;

  typedef struct packed {
    logic                 clear;
    logic                 advance;
    logic [NUM_LANES-1:0] capEn;
  } psds_strobe_t;
endpackage

// File: rtl/psds_capture.sv
module psds_capture #(
  parameter int REG_W = 4
) (
  input  logic             clk,
  input  logic             clear,
  input  logic             load,
  input  logic [REG_W-1:0] din,
  output logic [REG_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (clear)     q <= '0;
    else if (load) q <= din;
  end
endmodule

// File: rtl/psds_ctrl.sv
module psds_ctrl
  import psds_pkg::*;
#(
  parameter int PTR_W = 4
) (
  input  logic             rst,
  input  logic             go,
  input  logic [PTR_W-1:0] ptrVal,
  output psds_strobe_t     strobes
);
  // Half-range split: a pointer at or above this value steers capture into lane 1.
  localparam logic [PTR_W-1:0] SPLIT = PTR_W'(1) << (PTR_W - 1);

  logic upperHalf;
  assign upperHalf = (ptrVal >= SPLIT);

  always_comb begin
    strobes.clear    = rst;
    strobes.advance  = go & ~rst;
    strobes.capEn[0] = go & ~rst & ~upperHalf;
    strobes.capEn[1] = go & ~rst &  upperHalf;
  end
endmodule

// File: rtl/psds_datapath.sv
module psds_datapath
  import psds_pkg::*;
#(
  parameter int PTR_W  = 4,
  parameter int DATA_W = 16,
  parameter int REG_W  = 4,
  parameter int A_LSB  = 2,
  parameter int B_LSB  = 6
) (
  input  logic             clk,
  input  psds_strobe_t     strobes,
  output logic [PTR_W-1:0] ptrVal,
  output logic [REG_W-1:0] regA,
  output logic [REG_W-1:0] regB
);
  localparam logic [PTR_W-1:0] PTR_START = '1;

  logic [DATA_W-1:0] dataCnt;
  logic [REG_W-1:0]  laneQ [NUM_LANES];

  always_ff @(posedge clk) begin
    if (strobes.clear)        ptrVal <= PTR_START;
    else if (strobes.advance) ptrVal <= ptrVal - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (strobes.clear)        dataCnt <= '0;
    else if (strobes.advance) dataCnt <= dataCnt + 1'b1;
  end

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    localparam int LSB = (g == 0) ? A_LSB : B_LSB;
    psds_capture #(.REG_W(REG_W)) u_cap (
      .clk   (clk),
      .clear (strobes.clear),
      .load  (strobes.capEn[g]),
      .din   (dataCnt[LSB +: REG_W]),
      .q     (laneQ[g])
    );
  end

  assign regA = laneQ[0];
  assign regB = laneQ[1];

  p_reset_init_r1: assert property (@(posedge clk)
    $past(strobes.clear) |-> (ptrVal == PTR_START && dataCnt == '0 && regA == '0 && regB == '0));

  p_ptr_step_r2: assert property (@(posedge clk) disable iff (strobes.clear)
    ($past(strobes.advance) && !$past(strobes.clear)) |-> ptrVal == $past(ptrVal) - 1'b1);

  p_data_step_r3: assert property (@(posedge clk) disable iff (strobes.clear)
    ($past(strobes.advance) && !$past(strobes.clear)) |-> dataCnt == $past(dataCnt) + 1'b1);

  p_cap_a_r4: assert property (@(posedge clk) disable iff (strobes.clear)
    ($past(strobes.advance) && !$past(strobes.clear) && !$past(ptrVal[PTR_W-1]))
      |-> (regA == $past(dataCnt[A_LSB +: REG_W]) && $stable(regB)));

  p_cap_b_r5: assert property (@(posedge clk) disable iff (strobes.clear)
    ($past(strobes.advance) && !$past(strobes.clear) && $past(ptrVal[PTR_W-1]))
      |-> (regB == $past(dataCnt[B_LSB +: REG_W]) && $stable(regA)));

  p_idle_hold_r6: assert property (@(posedge clk) disable iff (strobes.clear)
    (!$past(strobes.advance) && !$past(strobes.clear))
      |-> ($stable(ptrVal) && $stable(dataCnt) && $stable(regA) && $stable(regB)));
endmodule

// File: rtl/psds_top.sv
module psds_top
  import psds_pkg::*;
#(
  parameter int PTR_W  = 4,
  parameter int DATA_W = 16,
  parameter int REG_W  = 4,
  parameter int A_LSB  = 2,
  parameter int B_LSB  = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  output logic [REG_W-1:0] sampleA,
  output logic [REG_W-1:0] sampleB
);
  psds_strobe_t     strobes;
  logic [PTR_W-1:0] ptrVal;

  psds_ctrl #(.PTR_W(PTR_W)) u_ctrl (
    .rst     (rst),
    .go      (go),
    .ptrVal  (ptrVal),
    .strobes (strobes)
  );

  psds_datapath #(
    .PTR_W(PTR_W), .DATA_W(DATA_W), .REG_W(REG_W), .A_LSB(A_LSB), .B_LSB(B_LSB)
  ) u_dp (
    .clk     (clk),
    .strobes (strobes),
    .ptrVal  (ptrVal),
    .regA    (sampleA),
    .regB    (sampleB)
  );
endmodule

// File: tb/sim_psds_top.sv
module sim_psds_top;
  localparam int DW = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic go  = 1'b0;
  logic [3:0] sampleA, sampleB;

  always #2 clk = ~clk;

  psds_top #(.PTR_W(4), .DATA_W(DW), .REG_W(4), .A_LSB(2), .B_LSB(6)) u0 (
    .clk(clk), .rst(rst), .go(go), .sampleA(sampleA), .sampleB(sampleB)
  );

  typedef struct {
    logic [3:0] a;
    logic [3:0] b;
    string      tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [3:0]    mPtr  = 4'hF;
  logic [DW-1:0] mData = '0;
  logic [3:0]    mA    = '0;
  logic [3:0]    mB    = '0;

  task automatic drive(input logic goV, input logic rstV, input string tag);
    exp_t e;
    @(negedge clk);
    go  = goV;
    rst = rstV;
    if (rstV) begin
      mPtr = 4'hF; mData = '0; mA = '0; mB = '0;
    end else if (goV) begin
      if (mPtr < 4'd8) mA = mData[5:2];
      else             mB = mData[9:6];
      mPtr  = mPtr - 4'd1;
      mData = mData + 1'b1;
    end
    e.a = mA; e.b = mB; e.tag = tag;
    q.push_back(e);
  endtask

  initial begin
    forever begin
      exp_t e;
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        e = q.pop_front();
        checks++;
        if (sampleA !== e.a || sampleB !== e.b) begin
          errors++;
          $display("FAIL %s: actual A=%h B=%h expected A=%h B=%h", e.tag, sampleA, sampleB, e.a, e.b);
        end
      end
    end
  end

  initial begin
    // R1: reset state
    drive(1'b0, 1'b1, "R1");
    drive(1'b0, 1'b1, "R1");
    // R2 R4 R5 R8: run across several pointer wraps and A/B splits
    for (int i = 0; i < 40; i++) drive(1'b1, 1'b0, "R2 R4 R5 R8");
    // R6: idle hold
    for (int i = 0; i < 6; i++) drive(1'b0, 1'b0, "R6");
    for (int i = 0; i < 5; i++) drive(1'b1, 1'b0, "R4 R5");
    drive(1'b0, 1'b0, "R6");
    // R3: long run crossing the data counter wrap
    for (int i = 0; i < 1100; i++) drive(1'b1, 1'b0, "R3");
    // R7: reset mid-run with go still high
    drive(1'b1, 1'b1, "R7");
    for (int i = 0; i < 20; i++) drive(1'b1, 1'b0, "R7");
    drive(1'b0, 1'b1, "R1");
    drive(1'b0, 1'b0, "R6");
    @(negedge clk);
    @(negedge clk);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #800000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung run expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule